// File: doc/BRIEF.md
# Debug Breakpoint and Cycle Counter Unit

This block sits next to a small CPU core and decides when the core must stop for debugging. It keeps one 16-bit debug counter, a control register and a status register, all reached through a simple synchronous register port. It watches the core's program counter, a "CPU running" qualifier and a strobe that fires when a software break instruction executes. It drives a debug-mode flag, mirrored on `cpu_halt`, which freezes the core. It can also ask for a timed system reset that does not disturb the unit's own registers.

The counter has two roles, chosen by a control bit. In counting mode it counts down once per running cycle. It saturates at zero and can raise a break on the step that reaches zero. In address-match mode the counter is frozen and acts as a breakpoint address compared against the program counter.

Two state machines carry the behaviour. The debug machine has the states RUN and STOP:
- RUN goes to STOP on a break hit or on a control write with the debug bit set.
- STOP goes back to RUN on a control write with the debug bit clear, unless a break hit occurs in the same cycle.

The reset sequencer has the states IDLE and PULSE:
- IDLE goes to PULSE on a control write with the reset bit set.
- PULSE goes back to IDLE after a fixed number of cycles.

Top module: `dbg_brk_unit`

## Requirements
- R1: After reset the counter, control and status registers read 0, and `dbg_mode`, `cpu_halt` and `sys_rst_req` are low. Register addresses: 0 = counter (16 bits), 1 = control, 2 = status.
- R2: When control bit 6 (address-match enable) is 0, the counter decrements by one at each clock edge where `cpu_run` is 1 and debug mode is 0. It holds its value while `cpu_run` is 0.
- R3: The counter stops at 0000h and never wraps.
- R4: When control bit 5 (zero-break enable) is 1, the step that takes the counter from 1 to 0 also sets debug mode at the same edge. When bit 5 is 0, reaching zero does not set debug mode.
- R5: When control bit 6 is 1, the counter does not count. A running cycle with `cpu_pc` equal to the counter sets debug mode at the next edge.
- R6: Control bit 7 reads back the debug mode, and writing it sets or clears debug mode. `cpu_halt` equals `dbg_mode`.
- R7: A control write that takes debug mode from 1 to 0 clears the counter if zero-break is disabled, and keeps the counter's value if zero-break is enabled.
- R8: A break hit in the same cycle as a control write with bit 7 = 0 leaves debug mode at 1.
- R9: Status bit 7 (idle) reads 1 while debug mode is 1, or after a `brk_strobe` pulse until the next control write. A strobe in the same cycle as a control write leaves idle set.
- R10: Writing control bit 0 = 1 asserts `sys_rst_req` for exactly 16 cycles. Control bit 0 reads 1 during the pulse and 0 after it, and the counter keeps its value.
- R11: Status bit 6 shows `halt_in` and status bit 5 shows `rdprot_in`. The other status bits read 0. Control bits 4 to 1 are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| cpu_pc | input | 16 | CPU program counter |
| cpu_run | input | 1 | CPU executing this cycle |
| brk_strobe | input | 1 | Break instruction executed |
| halt_in | input | 1 | CPU in its halt state |
| rdprot_in | input | 1 | Memory read protection active |
| dbg_mode | output | 1 | Debug mode flag |
| cpu_halt | output | 1 | Stop request to the CPU |
| sys_rst_req | output | 1 | System reset request |

## Verification
A debug machine stuck in the wrong state shows on `dbg_mode` and `cpu_halt` at the edge after the triggering event. For a zero break it shows at the same edge where the counter reads 0. A counter that steps at the wrong time, wraps, or is cleared or kept wrongly on exit shows in a register read within one cycle. A reset sequencer with a wrong cycle count shows as a `sys_rst_req` pulse that is not exactly 16 cycles long. Idle-flag and priority errors appear on the first status read after the colliding write.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
    typedef enum logic {DBG_RUN = 1'b0, DBG_STOP = 1'b1} dbg_state_t;
    typedef enum logic {RS_IDLE = 1'b0, RS_PULSE = 1'b1} rst_state_t;

    localparam logic [1:0] ADDR_CNT  = 2'd0;
    localparam logic [1:0] ADDR_CTL  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int CTL_DBG_BIT  = 7;
    localparam int CTL_PCEN_BIT = 6;
    localparam int CTL_ZEN_BIT  = 5;
    localparam int CTL_RST_BIT  = 0;
endpackage

// File: rtl/dbg_cnt_unit.sv
module dbg_cnt_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             pc_mode,
    input  logic             zero_en,
    input  logic             run_en,
    input  logic             dbg_exit,
    input  logic [CNT_W-1:0] pc,
    output logic [CNT_W-1:0] cnt,
    output logic             pc_hit,
    output logic             zero_hit
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dbg_exit && !zero_en)
            cnt <= '0;
        else if (!pc_mode && run_en && cnt != '0)
            cnt <= cnt - ONE;
    end

    always_comb begin
        pc_hit   = pc_mode && run_en && (pc == cnt);
        zero_hit = !pc_mode && zero_en && run_en && !load && (cnt == ONE);
    end

    // R5
    cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_mode && !load && !dbg_exit) |=> $stable(cnt));

    // R3
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> (cnt == '0));
endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
    import dbg_brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic wr_dbg_bit,
    input  logic brk_hit,
    input  logic brk_strobe,
    output logic dbg_exit,
    output logic dbg_mode,
    output logic cpu_halt,
    output logic idle
);
    dbg_state_t state, state_nx;
    logic       brk_seen;

    always_comb begin
        state_nx = state;
        unique case (state)
            DBG_RUN:  if (brk_hit || (ctl_wr && wr_dbg_bit)) state_nx = DBG_STOP;
            DBG_STOP: if (ctl_wr && !wr_dbg_bit && !brk_hit) state_nx = DBG_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= DBG_RUN;
            brk_seen <= 1'b0;
        end else begin
            state <= state_nx;
            if (brk_strobe)
                brk_seen <= 1'b1;
            else if (ctl_wr)
                brk_seen <= 1'b0;
        end
    end

    always_comb begin
        dbg_mode = (state == DBG_STOP);
        cpu_halt = (state == DBG_STOP);
        idle     = (state == DBG_STOP) || brk_seen;
        dbg_exit = (state == DBG_STOP) && (state_nx == DBG_RUN);
    end

    // R8
    brk_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_hit |=> dbg_mode);

    // R9
    idle_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_strobe |=> idle);
endmodule

// File: rtl/dbg_rst_seq.sv
module dbg_rst_seq
    import dbg_brk_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic rst_req
);
    localparam int TW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(RST_CYCLES - 1);

    rst_state_t      state;
    logic [TW-1:0]   tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_IDLE;
            tick  <= '0;
        end else begin
            unique case (state)
                RS_IDLE: begin
                    tick <= '0;
                    if (start) state <= RS_PULSE;
                end
                RS_PULSE: begin
                    if (tick == LAST) begin
                        state <= RS_IDLE;
                        tick  <= '0;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb rst_req = (state == RS_PULSE);

    // R10
    rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && tick != LAST) |=> rst_req);

    // R10
    rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(start));
endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit
    import dbg_brk_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int AW         = 2,
    parameter int RST_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0] cpu_pc,
    input  logic             cpu_run,
    input  logic             brk_strobe,
    input  logic             halt_in,
    input  logic             rdprot_in,
    output logic             dbg_mode,
    output logic             cpu_halt,
    output logic             sys_rst_req
);
    localparam int PADW = CNT_W - 8;

    logic             cnt_wr, ctl_wr;
    logic             pc_mode, zero_en;
    logic             pc_hit, zero_hit, dbg_exit, idle;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       ctl_rd, stat_rd;

    always_comb begin
        cnt_wr = reg_wr && (reg_addr == AW'(ADDR_CNT));
        ctl_wr = reg_wr && (reg_addr == AW'(ADDR_CTL));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_mode <= 1'b0;
            zero_en <= 1'b0;
        end else if (ctl_wr) begin
            pc_mode <= reg_wdata[CTL_PCEN_BIT];
            zero_en <= reg_wdata[CTL_ZEN_BIT];
        end
    end

    dbg_cnt_unit #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_wr),
        .load_val (reg_wdata),
        .pc_mode  (pc_mode),
        .zero_en  (zero_en),
        .run_en   (cpu_run && !dbg_mode),
        .dbg_exit (dbg_exit),
        .pc       (cpu_pc),
        .cnt      (cnt),
        .pc_hit   (pc_hit),
        .zero_hit (zero_hit)
    );

    dbg_mode_fsm mode_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .wr_dbg_bit (reg_wdata[CTL_DBG_BIT]),
        .brk_hit    (pc_hit || zero_hit),
        .brk_strobe (brk_strobe),
        .dbg_exit   (dbg_exit),
        .dbg_mode   (dbg_mode),
        .cpu_halt   (cpu_halt),
        .idle       (idle)
    );

    dbg_rst_seq #(.RST_CYCLES(RST_CYCLES)) rst_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (ctl_wr && reg_wdata[CTL_RST_BIT]),
        .rst_req (sys_rst_req)
    );

    always_comb begin
        ctl_rd  = {dbg_mode, pc_mode, zero_en, 4'b0000, sys_rst_req};
        stat_rd = {idle, halt_in, rdprot_in, 5'b00000};
        unique case (reg_addr)
            AW'(ADDR_CNT):  reg_rdata = cnt;
            AW'(ADDR_CTL):  reg_rdata = {{PADW{1'b0}}, ctl_rd};
            AW'(ADDR_STAT): reg_rdata = {{PADW{1'b0}}, stat_rd};
            default:        reg_rdata = '0;
        endcase
    end

    // R6
    halt_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt == dbg_mode));
endmodule

// File: tb/dbg_brk_unit_tb_top.sv
module dbg_brk_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] cpu_pc = '0;
    logic        cpu_run = 1'b0;
    logic        brk_strobe = 1'b0;
    logic        halt_in = 1'b0;
    logic        rdprot_in = 1'b0;
    logic        dbg_mode, cpu_halt, sys_rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dbg_brk_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_pc(cpu_pc),
        .cpu_run(cpu_run), .brk_strobe(brk_strobe), .halt_in(halt_in),
        .rdprot_in(rdprot_in), .dbg_mode(dbg_mode), .cpu_halt(cpu_halt),
        .sys_rst_req(sys_rst_req)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run_cycles(int n);
        @(negedge clk);
        cpu_run = 1'b1;
        repeat (n) @(negedge clk);
        cpu_run = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [15:0] v;
        rd(2'd0, v); check("R1 cnt", v, 16'h0000);
        rd(2'd1, v); check("R1 ctl", v, 16'h0000);
        rd(2'd2, v); check("R1 stat", v, 16'h0000);
        check("R1 outs", {13'd0, dbg_mode, cpu_halt, sys_rst_req}, 16'h0000);
    endtask

    task automatic t_decrement();
        logic [15:0] v;
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'd10);
        run_cycles(3);
        rd(2'd0, v); check("R2 dec", v, 16'd7);
        repeat (2) @(negedge clk);
        rd(2'd0, v); check("R2 hold", v, 16'd7);
    endtask

    task automatic t_saturate();
        logic [15:0] v;
        wr(2'd0, 16'd2);
        run_cycles(5);
        rd(2'd0, v); check("R3 sat", v, 16'd0);
        check("R4 no zero break when off", {15'd0, dbg_mode}, 16'd0);
    endtask

    task automatic t_zero_break();
        logic [15:0] v;
        wr(2'd1, 16'h0020);
        wr(2'd0, 16'd3);
        @(negedge clk);
        cpu_run = 1'b1;
        repeat (2) @(negedge clk);
        rd(2'd0, v); check("R4 cnt before", v, 16'd1);
        check("R4 dbg before", {15'd0, dbg_mode}, 16'd0);
        @(negedge clk);
        rd(2'd0, v); check("R4 cnt zero", v, 16'd0);
        check("R4 dbg set", {15'd0, dbg_mode}, 16'd1);
        check("R6 halt mirrors", {15'd0, cpu_halt}, 16'd1);
        cpu_run = 1'b0;
    endtask

    task automatic t_exit();
        logic [15:0] v;
        wr(2'd0, 16'd5);
        wr(2'd1, 16'h0020);
        rd(2'd0, v); check("R7 kept with zero-break", v, 16'd5);
        check("R6 clear dbg", {15'd0, dbg_mode}, 16'd0);
        wr(2'd1, 16'h0080);
        check("R6 set dbg", {14'd0, dbg_mode, cpu_halt}, 16'd3);
        rd(2'd1, v); check("R6 ctl read", v, 16'h0080);
        wr(2'd0, 16'd9);
        wr(2'd1, 16'h0000);
        rd(2'd0, v); check("R7 cleared without zero-break", v, 16'd0);
    endtask

    task automatic t_pc_break();
        logic [15:0] v;
        wr(2'd1, 16'h0040);
        wr(2'd0, 16'h1234);
        cpu_pc = 16'h1000;
        run_cycles(3);
        rd(2'd0, v); check("R5 frozen", v, 16'h1234);
        check("R5 no break", {15'd0, dbg_mode}, 16'd0);
        @(negedge clk);
        cpu_pc = 16'h1234; cpu_run = 1'b1;
        @(negedge clk);
        cpu_run = 1'b0; cpu_pc = 16'h0000;
        check("R5 break on match", {15'd0, dbg_mode}, 16'd1);
        wr(2'd1, 16'h0040);
    endtask

    task automatic t_priority();
        logic [15:0] v;
        wr(2'd0, 16'h1234);
        @(negedge clk);
        cpu_pc = 16'h1234; cpu_run = 1'b1;
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0040;
        @(negedge clk);
        reg_wr = 1'b0; cpu_run = 1'b0; cpu_pc = 16'h0000;
        check("R8 break beats write", {15'd0, dbg_mode}, 16'd1);
        wr(2'd1, 16'h0000);
        rd(2'd0, v); check("R8 exit", {15'd0, dbg_mode}, 16'd0);
    endtask

    task automatic t_idle();
        logic [15:0] v;
        rd(2'd2, v); check("R9 idle clear", v, 16'h0000);
        @(negedge clk); brk_strobe = 1'b1;
        @(negedge clk); brk_strobe = 1'b0;
        repeat (2) @(negedge clk);
        rd(2'd2, v); check("R9 idle held", v, 16'h0080);
        wr(2'd1, 16'h0000);
        rd(2'd2, v); check("R9 idle cleared by write", v, 16'h0000);
        @(negedge clk);
        brk_strobe = 1'b1;
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0000;
        @(negedge clk);
        brk_strobe = 1'b0; reg_wr = 1'b0;
        rd(2'd2, v); check("R9 strobe beats write", v, 16'h0080);
        wr(2'd1, 16'h0080);
        rd(2'd2, v); check("R9 idle in debug", v, 16'h0080);
        wr(2'd1, 16'h0000);
    endtask

    task automatic t_sys_reset();
        logic [15:0] v;
        int high;
        wr(2'd0, 16'h0055);
        wr(2'd1, 16'h0001);
        rd(2'd1, v); check("R10 rst bit set", v, 16'h0001);
        high = 0;
        while (sys_rst_req && high < 40) begin
            high++;
            @(negedge clk);
        end
        check("R10 pulse length", 16'(high), 16'd16);
        rd(2'd1, v); check("R10 rst bit cleared", v, 16'h0000);
        rd(2'd0, v); check("R10 cnt kept", v, 16'h0055);
    endtask

    task automatic t_status_bits();
        logic [15:0] v;
        halt_in = 1'b1; rdprot_in = 1'b1;
        #1 rd(2'd2, v); check("R11 status flags", v, 16'h0060);
        halt_in = 1'b0;
        #1 rd(2'd2, v); check("R11 rpen only", v, 16'h0020);
        rdprot_in = 1'b0;
        wr(2'd1, 16'h001E);
        rd(2'd1, v); check("R11 reserved ctl", v, 16'h0000);
        check("R11 reserved no effect", {14'd0, dbg_mode, sys_rst_req}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_decrement();
        t_saturate();
        t_zero_break();
        t_exit();
        t_pc_break();
        t_priority();
        t_idle();
        t_sys_reset();
        t_status_bits();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule